// File: doc/BRIEF.md
# Multiplexed Segment LCD Controller

This block is the digital controller for a segment LCD panel driven in duplex, triplex or quad multiplex. It holds one configuration byte and a small segment data memory, both on a byte-wide register bus. It steps a common-phase counter on a strobe taken from one of two timing sources. For the active common, it presents each segment's data bit as a logic level. The analog stage after it turns these logic levels into waveform voltages. That stage, with its bias ladder and charge pump, is not part of this block.

There are seventeen segment positions. Fifteen have pins of their own. The other two sit on shared pins, and the multiplex setting decides whether each shared pin carries segment data or a common phase. The display is gated by an enable bit. It can also be forced dark while the sleep input is high, if the sleep override bit is set. A blink mode blanks every segment and restores it at a rate of about 2 Hz. Each blank or restore takes effect only at a frame boundary.

Top module: `segmux_lcd_ctrl`

## Requirements
- R1: After reset, the configuration byte and every segment data register read 0, and all common, segment and shared-pin outputs are 0.
- R2: Address 0 is the configuration byte. Bit 7 is enable, bit 5 is blink, bit 4 is sleep override, bit 3 is slow-source select, bit 2 is a stored bias flag and bits 1:0 are the multiplex code. All of these read back as written, and bit 6 always reads 0.
- R3: A configuration write with bit 6 set zeroes all segment data registers on that clock edge.
- R4: While enable is 0, all common, segment and shared-pin outputs are 0 and strobes do not move the phase.
- R5: With sleep override set, a high sleep input turns the display off. With sleep override clear, the sleep input has no effect.
- R6: Multiplex code 00 turns the display off and gives both shared pins the segment role.
- R7: The phase advances by one on each strobe of the selected source: tick_fast_i when bit 3 is 0, tick_slow_i when bit 3 is 1. It wraps to 0 after phase N-1, where N is 2, 3 or 4 for codes 01, 10 and 11. The active common output is one-hot, and strobes of the other source are ignored. On every change of configuration the phase restarts at 0.
- R8: Shared pin 0 acts as common 3 only under code 11. Shared pin 1 acts as common 2 under codes 10 and 11. Otherwise each shared pin acts as a segment line: pin 0 is segment 15 and pin 1 is segment 16.
- R9: Segment line i outputs bit p of data register i, where p is the current phase.
- R10: frame_pol_o toggles at each phase wrap and is 0 whenever the display is off.
- R11: With blink on, every DIV_SLOW (default 32) slow strobes or DIV_FAST (default 512) fast strobes marks a blink toggle. The toggle is applied at the next frame wrap, or at that same strobe if it is also a wrap. While blanked, segment outputs are 0 but commons keep running.
- R12: Segment register i sits at address i+1 and holds the low 4 bits of a write. Addresses above 17 read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| sleep_i | input | 1 | Sleep-mode indication |
| tick_fast_i | input | 1 | Fast timing strobe, one cycle per period |
| tick_slow_i | input | 1 | Slow timing strobe, one cycle per period |
| com_o | output | 2 | Commons 0 and 1, high while active |
| seg_o | output | DSEG | Dedicated segment levels |
| shr_o | output | 2 | Shared pin levels |
| shr_is_com_o | output | 2 | High where a shared pin acts as a common |
| frame_pol_o | output | 1 | Frame polarity |

## Verification
The hardest case to reach is a blink toggle that falls in the middle of a frame, where the toggle must wait for the frame to end. The bench selects the slow source with a three-common code, so the 32nd strobe lands one strobe before a frame wrap. It then checks that segments are still visible after strobe 32 and blank after strobe 33. It also reaches each shared-pin role, and the phase reset caused by a mid-run configuration change, by walking all three multiplex codes over two full frames each.

// File: rtl/segmux_pkg.sv
package segmux_pkg;

  typedef struct packed {
    logic       en;
    logic       blink;
    logic       slp_ovr;
    logic       clk_slow;
    logic       bias;
    logic [1:0] mux;
  } cfg_t;

  // number of commons for a multiplex code (0 = off)
  function automatic logic [2:0] ncom_of(input logic [1:0] m);
    return (m == 2'b00) ? 3'd0 : ({1'b0, m} + 3'd1);
  endfunction

  // [0]: shared pin 0 is common 3, [1]: shared pin 1 is common 2
  function automatic logic [1:0] pin_role(input logic [1:0] m);
    return {m[1], (m == 2'b11)};
  endfunction

  function automatic logic [7:0] cfg_byte(input cfg_t c);
    return {c.en, 1'b0, c.blink, c.slp_ovr, c.clk_slow, c.bias, c.mux};
  endfunction

endpackage

// File: rtl/segmux_regs.sv
module segmux_regs
  import segmux_pkg::*;
#(
  parameter int NSEG   = 17,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output cfg_t              cfg,
  output logic              cfg_wr,
  output logic              clr_evt,
  output logic [NSEG*4-1:0] seg_data
);

  logic [3:0] mem [NSEG];

  assign cfg_wr  = we && (addr == '0);
  assign clr_evt = cfg_wr && wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr) begin
      cfg <= '{en: wdata[7], blink: wdata[5], slp_ovr: wdata[4],
               clk_slow: wdata[3], bias: wdata[2], mux: wdata[1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSEG; i++) mem[i] <= '0;
    end else if (clr_evt) begin
      for (int i = 0; i < NSEG; i++) mem[i] <= '0;
    end else if (we) begin
      for (int i = 0; i < NSEG; i++)
        if (addr == ADDR_W'(i + 1)) mem[i] <= wdata[3:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) rdata = cfg_byte(cfg);
    for (int i = 0; i < NSEG; i++)
      if (addr == ADDR_W'(i + 1)) rdata = {4'b0, mem[i]};
  end

  for (genvar g = 0; g < NSEG; g++) begin : g_flat
    assign seg_data[g*4 +: 4] = mem[g];
  end

endmodule

// File: rtl/segmux_phase.sv
module segmux_phase (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic       adv,
  input  logic [2:0] ncom,
  output logic [1:0] phase,
  output logic       pol,
  output logic       frame_evt
);

  logic last;
  assign last      = ({1'b0, phase} >= (ncom - 3'd1));
  assign frame_evt = run && adv && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pol   <= 1'b0;
    end else if (!run || restart) begin
      phase <= '0;
      pol   <= 1'b0;
    end else if (adv) begin
      if (last) begin
        phase <= '0;
        pol   <= ~pol;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

endmodule

// File: rtl/segmux_blink.sv
module segmux_blink #(
  parameter int DIV_FAST = 512,
  parameter int DIV_SLOW = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic slow,
  input  logic adv,
  input  logic frame_evt,
  output logic blank
);

  localparam int DMAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int CW   = $clog2(DMAX + 1);

  logic [CW-1:0] cnt, lim;
  logic          pend, hit;

  assign lim = slow ? CW'(DIV_SLOW - 1) : CW'(DIV_FAST - 1);
  assign hit = adv && (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pend  <= 1'b0;
      blank <= 1'b0;
    end else if (!run || restart) begin
      cnt   <= '0;
      pend  <= 1'b0;
      blank <= 1'b0;
    end else begin
      if (adv) cnt <= hit ? '0 : cnt + 1'b1;
      if (frame_evt && (pend || hit)) begin
        blank <= ~blank;
        pend  <= 1'b0;
      end else if (hit) begin
        pend <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/segmux_lcd_ctrl.sv
module segmux_lcd_ctrl
  import segmux_pkg::*;
#(
  parameter int DSEG     = 15,
  parameter int ADDR_W   = 5,
  parameter int DIV_FAST = 512,
  parameter int DIV_SLOW = 32
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              sleep_i,
  input  logic              tick_fast_i,
  input  logic              tick_slow_i,
  output logic [1:0]        com_o,
  output logic [DSEG-1:0]   seg_o,
  output logic [1:0]        shr_o,
  output logic [1:0]        shr_is_com_o,
  output logic              frame_pol_o
);

  localparam int NSEG = DSEG + 2;

  cfg_t              cfg;
  logic              cfg_wr, clr_evt, disp_on, adv, frame_evt, pol, blank;
  logic [NSEG*4-1:0] seg_data;
  logic [2:0]        ncom;
  logic [1:0]        phase;
  logic [3:0]        com_lvl;
  logic [NSEG-1:0]   seg_lvl;

  segmux_regs #(.NSEG(NSEG), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk_i), .rst_n(rst_n_i), .we(bus_we_i), .addr(bus_addr_i),
    .wdata(bus_wdata_i), .rdata(bus_rdata_o), .cfg(cfg), .cfg_wr(cfg_wr),
    .clr_evt(clr_evt), .seg_data(seg_data)
  );

  assign disp_on = cfg.en && !(cfg.slp_ovr && sleep_i) && (cfg.mux != 2'b00);
  assign ncom    = ncom_of(cfg.mux);
  assign adv     = cfg.clk_slow ? tick_slow_i : tick_fast_i;

  segmux_phase u_phase (
    .clk(clk_i), .rst_n(rst_n_i), .run(disp_on), .restart(cfg_wr),
    .adv(adv), .ncom(ncom), .phase(phase), .pol(pol), .frame_evt(frame_evt)
  );

  segmux_blink #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_blink (
    .clk(clk_i), .rst_n(rst_n_i), .run(disp_on && cfg.blink),
    .restart(cfg_wr), .slow(cfg.clk_slow), .adv(adv),
    .frame_evt(frame_evt), .blank(blank)
  );

  for (genvar c = 0; c < 4; c++) begin : g_com
    assign com_lvl[c] = disp_on && (phase == 2'(c));
  end

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_lvl[s] = disp_on && !blank && seg_data[s*4 + int'(phase)];
  end

  assign shr_is_com_o = pin_role(cfg.mux);
  assign com_o        = com_lvl[1:0];
  assign seg_o        = seg_lvl[DSEG-1:0];
  assign shr_o[0]     = shr_is_com_o[0] ? com_lvl[3] : seg_lvl[DSEG];
  assign shr_o[1]     = shr_is_com_o[1] ? com_lvl[2] : seg_lvl[DSEG+1];
  assign frame_pol_o  = pol;

endmodule

// File: rtl/segmux_chk.sv
module segmux_chk #(
  parameter int DSEG = 15,
  parameter int NSEG = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_en,
  input logic [1:0]        mux,
  input logic              disp_on,
  input logic              adv,
  input logic              cfg_wr,
  input logic [1:0]        phase,
  input logic [2:0]        ncom,
  input logic              frame_evt,
  input logic              pol,
  input logic              clr_evt,
  input logic [NSEG*4-1:0] seg_data,
  input logic [1:0]        com_o,
  input logic [DSEG-1:0]   seg_o,
  input logic [1:0]        shr_is_com
);

  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> (com_o == 2'b00 && seg_o == '0));

  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    disp_on |-> ({1'b0, phase} < ncom));

  assert_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_on && !adv && !cfg_wr) |=> (!disp_on || $stable(phase)));

  assert_com_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com_o));

  assert_pol_flip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_evt && !cfg_wr) |=> (!disp_on || pol != $past(pol)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (seg_data == '0));

  assert_role_quad_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mux == 2'b11) |-> (shr_is_com == 2'b11));

  assert_role_duplex_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mux == 2'b01) |-> (shr_is_com == 2'b00));

endmodule

bind segmux_lcd_ctrl segmux_chk #(.DSEG(DSEG), .NSEG(NSEG)) u_chk (
  .clk(clk_i), .rst_n(rst_n_i), .cfg_en(cfg.en), .mux(cfg.mux),
  .disp_on(disp_on), .adv(adv), .cfg_wr(cfg_wr), .phase(phase), .ncom(ncom),
  .frame_evt(frame_evt), .pol(pol), .clr_evt(clr_evt), .seg_data(seg_data),
  .com_o(com_o), .seg_o(seg_o), .shr_is_com(shr_is_com_o)
);

// File: tb/sim_segmux_lcd_ctrl.sv
module sim_segmux_lcd_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DSEG = 15;
  localparam int NSEG = 17;
  localparam int AW   = 5;

  logic            clk = 1'b0, rst_n = 1'b0;
  logic            we = 1'b0, sleep = 1'b0, tf = 1'b0, ts = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [7:0]      wdata = '0, rdata;
  logic [1:0]      com, shr, shr_com;
  logic [DSEG-1:0] seg;
  logic            fpol;

  int checks = 0, fails = 0;
  logic [3:0] bdat [NSEG];

  always #(CLK_PERIOD/2) clk = ~clk;

  segmux_lcd_ctrl u0 (
    .clk_i(clk), .rst_n_i(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .sleep_i(sleep),
    .tick_fast_i(tf), .tick_slow_i(ts), .com_o(com), .seg_o(seg),
    .shr_o(shr), .shr_is_com_o(shr_com), .frame_pol_o(fpol)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    addr = AW'(a); #1; d = rdata;
  endtask

  task automatic tick(input bit slow);
    @(negedge clk); if (slow) ts = 1'b1; else tf = 1'b1;
    @(negedge clk); ts = 1'b0; tf = 1'b0;
  endtask

  // bench model of outputs for a given phase
  task automatic expect_out(input string req, input int p, input logic [1:0] m,
                            input bit on, input bit blanked, input bit pl);
    logic [1:0] ecom, eshr, erole;
    logic [DSEG-1:0] eseg;
    for (int i = 0; i < DSEG; i++) eseg[i] = on && !blanked && bdat[i][p];
    ecom = on ? ((p == 0) ? 2'b01 : (p == 1) ? 2'b10 : 2'b00) : 2'b00;
    erole[0] = (m == 2'b11);
    erole[1] = (m == 2'b10) || (m == 2'b11);
    eshr[0] = erole[0] ? (on && p == 3) : (on && !blanked && bdat[DSEG][p]);
    eshr[1] = erole[1] ? (on && p == 2) : (on && !blanked && bdat[DSEG+1][p]);
    chk({req, " com"}, 32'(com), 32'(ecom));
    chk({req, " seg"}, 32'(seg), 32'(eseg));
    chk({req, " shr"}, 32'(shr), 32'(eshr));
    chk({req, " role R8"}, 32'(shr_com), 32'(erole));
    chk({req, " pol R10"}, 32'(fpol), 32'(on ? pl : 1'b0));
  endtask

  task automatic load_data(input int k);
    for (int i = 0; i < NSEG; i++) begin
      bdat[i] = 4'((i * k + 3) & 15);
      wr(i + 1, {4'hA, bdat[i]});
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 cfg", 32'(d), 0);
    for (int i = 1; i <= NSEG; i++) begin rd(i, d); chk("R1 data", 32'(d), 0); end
    chk("R1 outs", 32'({com, seg, shr, fpol}), 0);
  endtask

  task automatic t_cfg_readback;
    logic [7:0] d;
    wr(0, 8'h7F); rd(0, d); chk("R2 readback", 32'(d), 32'h3F);
    wr(0, 8'hA6); rd(0, d); chk("R2 readback", 32'(d), 32'hA6);
    wr(0, 8'h00);
  endtask

  task automatic t_data_regs;
    logic [7:0] d;
    load_data(7);
    for (int i = 0; i < NSEG; i++) begin rd(i + 1, d); chk("R12 data", 32'(d), 32'(bdat[i])); end
    wr(20, 8'hFF); rd(20, d); chk("R12 out of range", 32'(d), 0);
    for (int i = 0; i < NSEG; i++) begin rd(i + 1, d); chk("R12 untouched", 32'(d), 32'(bdat[i])); end
  endtask

  task automatic t_clear;
    logic [7:0] d;
    wr(0, 8'h40);
    for (int i = 0; i < NSEG; i++) begin
      bdat[i] = '0; rd(i + 1, d); chk("R3 cleared", 32'(d), 0);
    end
    rd(0, d); chk("R3 bit reads 0", 32'(d), 0);
  endtask

  task automatic t_disabled;
    load_data(5);
    wr(0, 8'h03);
    for (int k = 0; k < 3; k++) begin tick(0); expect_out("R4 off", 0, 2'b11, 0, 0, 0); end
  endtask

  task automatic t_scan(input logic [1:0] m);
    int n = int'(m) + 1, p = 0;
    bit pl = 0;
    wr(0, {6'b100000, m});
    expect_out("R9 start", 0, m, 1, 0, 0);
    for (int k = 0; k < 2 * n; k++) begin
      tick(1); expect_out("R7 other source", p, m, 1, 0, pl);
      tick(0);
      if (p == n - 1) begin p = 0; pl = ~pl; end else p++;
      expect_out("R9 scan", p, m, 1, 0, pl);
    end
  endtask

  task automatic t_slow_sel;
    wr(0, 8'h8A);
    tick(0); expect_out("R7 fast ignored", 0, 2'b10, 1, 0, 0);
    tick(1); expect_out("R7 slow step", 1, 2'b10, 1, 0, 0);
    tick(1); tick(1); expect_out("R7 slow wrap", 0, 2'b10, 1, 0, 1);
  endtask

  task automatic t_sleep;
    sleep = 1'b1;
    wr(0, 8'h93); expect_out("R5 forced off", 0, 2'b11, 0, 0, 0);
    tick(0); expect_out("R5 forced off", 0, 2'b11, 0, 0, 0);
    @(negedge clk); sleep = 1'b0; #1;
    expect_out("R5 wakes", 0, 2'b11, 1, 0, 0);
    @(negedge clk); sleep = 1'b1;
    wr(0, 8'h83); expect_out("R5 ignored", 0, 2'b11, 1, 0, 0);
    tick(0); expect_out("R5 ignored", 1, 2'b11, 1, 0, 0);
    sleep = 1'b0;
  endtask

  task automatic t_mux_off;
    wr(0, 8'h80);
    tick(0); expect_out("R6 reserved", 0, 2'b00, 0, 0, 0);
  endtask

  task automatic t_blink;
    load_data(3);
    wr(0, 8'hAA);
    for (int k = 1; k <= 32; k++) tick(1);
    // 32 ticks: phase 32 mod 3 = 2, pol after 10 wraps = 0, toggle pending
    expect_out("R11 waits for frame", 2, 2'b10, 1, 0, 0);
    tick(1);
    expect_out("R11 blanked", 0, 2'b10, 1, 1, 1);
    wr(0, 8'h8A);
    expect_out("R11 blink off", 0, 2'b10, 1, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_cfg_readback;
    t_data_regs;
    t_clear;
    t_disabled;
    load_data(7);
    t_scan(2'b01);
    t_scan(2'b10);
    t_scan(2'b11);
    t_slow_sel;
    t_sleep;
    t_mux_off;
    t_blink;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule